// File: doc/BRIEF.md
# Prescaled Periodic Interrupt Timer

This block is a timer peripheral for a small 8-bit processor. Firmware programs a 24-bit terminal count and a 4-bit clock divider through byte-wide port writes. Once the active terminal count is nonzero, an up-counter advances once per divided clock period. It runs from zero to the terminal count and wraps back to zero. Each wrap raises an interrupt request that lasts two system clocks. The live count is always visible on an output bus, so firmware can time how long an external signal stays asserted.

Both programmable values take effect only at safe points, so a period is never cut short and a division window is never broken:
- A new divider value waits until the current division window ends.
- New terminal-count bytes wait in a staging copy until the counter wraps.

The write port has no stream traffic and no back-pressure. It is a single-cycle strobe with an address and a data byte, and the block accepts a write in every cycle that the strobe is high.

Top module: `tmr_irq_top`

## Requirements
- R1: A synchronous reset (rst high) clears the count, the divider state, both terminal-count copies and the interrupt output. After reset the count stays at 0 and irq stays low until a nonzero terminal count has been written; writing only the divider does not start counting.
- R2: A write is taken when wr_en is high at a rising clock edge. Port ID 0x40 loads bits 7:0 of the staged terminal count, 0x41 loads bits 15:8, 0x42 loads bits 23:16, and 0x43 loads the divider from wr_data bits 3:0.
- R3: While the active terminal count T is nonzero, the count steps 0, 1, ..., T and then returns to 0, so the count never exceeds T. Successive interrupt rising edges are (T+1)*(P+1) clocks apart.
- R4: With divider value P, the count advances once every P+1 system clocks; P = 0 advances on every clock.
- R5: A divider value written while counting is applied only when the current division window ends. The step in progress keeps the old length, and later steps use the new length.
- R6: While the active terminal count is zero, the staged count becomes active on the next clock. While counting, staged bytes become active only at the wrap, so the period in progress keeps its old length.
- R7: When the count wraps, irq rises on the same clock edge that returns the count to 0 and stays high for exactly two clocks, unless a further wrap retriggers it.
- R8: cnt_value always shows the current counter value, with no added delay.
- R9: Writes to any other port ID, and any values on port_id and wr_data while wr_en is low, change no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Port write strobe |
| port_id | input | 8 | Port address of the write |
| wr_data | input | 8 | Write data byte |
| cnt_value | output | 24 | Live counter value |
| irq | output | 1 | Interrupt request pulse, two clocks wide |

## Verification
A corrupted counter or terminal count shows up at the ports within one period. It appears as a count above T on cnt_value, or as a wrong spacing between irq rising edges. A broken divider shows as a wrong gap between count changes, visible within P+1 clocks. A staging fault (a value applied too early) changes the length of the very period or step in which the write happened, so the bench measures that period and the one after it. A faulty pulse stretcher changes the irq high time on the first wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic              en;
    logic [BYTE_W-1:0] id;
    logic [BYTE_W-1:0] data;
  } port_wr_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned PS_W  = 4,
  parameter logic [7:0]  TC_ID0 = 8'h40,
  parameter logic [7:0]  PS_ID  = 8'h43
) (
  input  logic             clk,
  input  logic             rst,
  input  port_wr_t         wr,
  output logic [CNT_W-1:0] tc_staged,
  output logic [PS_W-1:0]  ps_staged
);
  localparam int unsigned NBYTES = (CNT_W + BYTE_W - 1) / BYTE_W;
  localparam int unsigned FULL_W = NBYTES * BYTE_W;

  logic [FULL_W-1:0] tc_bytes;

  // one staging byte per port ID, consecutive IDs from TC_ID0 upward
  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_tc_byte
    localparam logic [7:0] MY_ID = TC_ID0 + 8'(gi);
    always_ff @(posedge clk) begin
      if (rst)
        tc_bytes[gi*BYTE_W +: BYTE_W] <= '0;
      else if (wr.en && wr.id == MY_ID)
        tc_bytes[gi*BYTE_W +: BYTE_W] <= wr.data;
    end
  end

  assign tc_staged = tc_bytes[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)
      ps_staged <= '0;
    else if (wr.en && wr.id == PS_ID)
      ps_staged <= wr.data[PS_W-1:0];
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] ps_req,
  output logic            tick,
  output logic [PS_W-1:0] ps_act
);
  logic [PS_W-1:0] div_cnt;

  // a window ends when the divider count reaches the active value
  assign tick = run && (div_cnt == ps_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      ps_act  <= '0;
    end else if (!run || tick) begin
      div_cnt <= '0;
      ps_act  <= ps_req;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] tc_staged,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] tc_act,
  output logic             run,
  output logic             match
);
  assign run   = |tc_act;
  assign match = tick && (cnt == tc_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tc_act <= '0;
    end else if (!run) begin
      cnt    <= '0;
      tc_act <= tc_staged;
    end else if (match) begin
      cnt    <= '0;
      tc_act <= tc_staged;
    end else if (tick) begin
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_pulse.sv
module tmr_pulse #(
  parameter int unsigned PULSE_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic match,
  output logic irq
);
  localparam int unsigned LW = $clog2(PULSE_LEN + 1);

  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)
      left <= '0;
    else if (match)
      left <= LW'(PULSE_LEN);
    else if (left != '0)
      left <= left - 1'b1;
  end

  assign irq = (left != '0);
endmodule

// File: rtl/tmr_irq_top.sv
module tmr_irq_top
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned PS_W      = 4,
  parameter int unsigned PULSE_LEN = 2,
  parameter logic [7:0]  TC_ID0    = 8'h40,
  parameter logic [7:0]  PS_ID     = 8'h43
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       port_id,
  input  logic [7:0]       wr_data,
  output logic [CNT_W-1:0] cnt_value,
  output logic             irq
);
  port_wr_t         wr_w;
  logic [CNT_W-1:0] tc_staged_w;
  logic [PS_W-1:0]  ps_staged_w;
  logic [PS_W-1:0]  ps_act_w;
  logic [CNT_W-1:0] tc_act_w;
  logic             run_w;
  logic             tick_w;
  logic             match_w;

  assign wr_w = '{en: wr_en, id: port_id, data: wr_data};

  tmr_regs #(
    .CNT_W(CNT_W), .PS_W(PS_W), .TC_ID0(TC_ID0), .PS_ID(PS_ID)
  ) regs_i (
    .clk(clk), .rst(rst), .wr(wr_w),
    .tc_staged(tc_staged_w), .ps_staged(ps_staged_w)
  );

  tmr_prescaler #(.PS_W(PS_W)) presc_i (
    .clk(clk), .rst(rst), .run(run_w), .ps_req(ps_staged_w),
    .tick(tick_w), .ps_act(ps_act_w)
  );

  tmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick_w), .tc_staged(tc_staged_w),
    .cnt(cnt_value), .tc_act(tc_act_w), .run(run_w), .match(match_w)
  );

  tmr_pulse #(.PULSE_LEN(PULSE_LEN)) pulse_i (
    .clk(clk), .rst(rst), .match(match_w), .irq(irq)
  );
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned PS_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             match,
  input logic             run,
  input logic [PS_W-1:0]  ps_act,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tc_act,
  input logic             irq
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !irq));

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (tc_act != '0) |-> (cnt <= tc_act));

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
    match |=> (cnt == '0));

  p_hold_between_r4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  p_div_defer_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(ps_act));

  p_tc_defer_r6: assert property (@(posedge clk) disable iff (rst)
    (run && !match) |=> $stable(tc_act));

  p_irq_after_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    match |=> irq);

  p_irq_two_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |=> irq);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(match));
endmodule

bind tmr_irq_top tmr_irq_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) chk_i (
  .clk(clk), .rst(rst), .tick(tick_w), .match(match_w), .run(run_w),
  .ps_act(ps_act_w), .cnt(cnt_value), .tc_act(tc_act_w), .irq(irq)
);

// File: tb/tmr_irq_top_tb_top.sv
module tmr_irq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  port_id = 8'h00;
  logic [7:0]  wr_data = 8'h00;
  logic [23:0] cnt_value;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  tmr_irq_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .port_id(port_id),
    .wr_data(wr_data), .cnt_value(cnt_value), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // called at a negedge; the write lands at the next posedge
  task automatic wr(input logic [7:0] id, input logic [7:0] d);
    port_id = id; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic next_rise(output int n);
    logic p;
    n = 0; p = irq;
    forever begin
      @(negedge clk);
      n++;
      if (irq && !p) break;
      p = irq;
      if (n > 100000) break;
    end
  endtask

  // entered at the negedge where irq was first seen high
  task automatic period_meas(output int per, output int wid, output int mx);
    logic p;
    bit hi;
    per = 0; wid = 1; mx = int'(cnt_value); hi = 1'b1; p = 1'b1;
    forever begin
      @(negedge clk);
      per++;
      if (int'(cnt_value) > mx) mx = int'(cnt_value);
      if (hi) begin
        if (irq) wid++;
        else hi = 1'b0;
      end
      if (irq && !p) break;
      p = irq;
      if (per > 100000) break;
    end
  endtask

  task automatic next_change(output int n);
    logic [23:0] p;
    n = 0; p = cnt_value;
    forever begin
      @(negedge clk);
      n++;
      wr_en = 1'b0;
      if (cnt_value != p) break;
      if (n > 100000) break;
    end
  endtask

  initial begin
    int n, per, wid, mx;
    // R1: reset state and idle behaviour
    @(negedge clk);
    chk(cnt_value == 0 && !irq, "R1 reset outputs", int'(cnt_value), 0);
    do_reset();
    repeat (20) @(negedge clk);
    chk(cnt_value == 0, "R1 idle without terminal count", int'(cnt_value), 0);
    chk(!irq, "R1 no irq while idle", int'(irq), 0);
    wr(8'h43, 8'h02);
    repeat (6) @(negedge clk);
    chk(cnt_value == 0, "R1 divider alone does not start", int'(cnt_value), 0);

    // R3 R4 R7 R8: sweep of divider and terminal count
    for (int p = 0; p < 4; p++) begin
      for (int t = 2; t < 6; t++) begin
        do_reset();
        wr(8'h43, 8'(p));
        wr(8'h40, 8'(t));
        next_rise(n);
        chk(cnt_value == 0, "R7 count zero at irq rise", int'(cnt_value), 0);
        period_meas(per, wid, mx);
        chk(per == (t + 1) * (p + 1), "R3 R4 irq period", per, (t + 1) * (p + 1));
        chk(wid == 2, "R7 irq width", wid, 2);
        chk(mx == t, "R3 R8 peak count", mx, t);
      end
    end

    // R2: middle byte
    do_reset();
    wr(8'h41, 8'h01);
    next_rise(n);
    period_meas(per, wid, mx);
    chk(per == 257, "R2 middle byte period", per, 257);

    // R2: high byte alone starts the counter; enable at +1, first step at +2
    do_reset();
    wr(8'h42, 8'h01);
    repeat (5) @(negedge clk);
    chk(cnt_value == 4, "R2 high byte enables counting", int'(cnt_value), 4);

    // R5: divider change waits for the window in progress
    do_reset();
    wr(8'h43, 8'h03);
    wr(8'h40, 8'd200);
    next_change(n);
    port_id = 8'h43; wr_data = 8'h00; wr_en = 1'b1;
    next_change(n);
    chk(n == 4, "R5 step in progress keeps old length", n, 4);
    next_change(n);
    chk(n == 1, "R5 later step uses new length", n, 1);
    next_change(n);
    chk(n == 1, "R5 new length persists", n, 1);

    // R6: terminal count change waits for the wrap
    do_reset();
    wr(8'h40, 8'd20);
    next_rise(n);
    wr(8'h40, 8'd3);
    wr(8'h41, 8'd0);
    wr(8'h42, 8'd0);
    next_rise(n);
    chk(n == 18, "R6 period in progress keeps old count", n, 18);
    period_meas(per, wid, mx);
    chk(per == 4, "R6 next period uses new count", per, 4);

    // R9: stray IDs and unstrobed data are ignored
    do_reset();
    wr(8'h40, 8'd5);
    next_rise(n);
    port_id = 8'h40; wr_data = 8'h01; wr_en = 1'b0;
    @(negedge clk);
    wr(8'h44, 8'h01);
    wr(8'h3F, 8'h01);
    next_rise(n);
    period_meas(per, wid, mx);
    chk(per == 6, "R9 ignored writes leave period", per, 6);
    chk(mx == 5, "R9 ignored writes leave peak", mx, 5);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule